// File: doc/BRIEF.md
# Serial NAND Bad Block Scan Engine

This block builds a map of unusable erase blocks on a serial NAND device as soon as it leaves reset. It visits the blocks in ascending order. For each one it asks the device to load the first page of that block into its cache. It then polls the device status until the device is no longer busy, and reads sixteen bytes from the start of the spare area. A block counts as bad for either of two reasons. The first spare byte may differ from 0xFF, which is the factory marking. Or, when that byte is 0xFF, spare bytes 8 to 11 may carry a fixed 32-bit signature, which is the marking software leaves behind. The verdict goes into an internal one-bit-per-block memory, and a running count of bad blocks is kept next to it.

The engine does not shift bits on the wire. It hands whole command frames to an external serial shifter over a simple request/done link: up to four command bytes packed into one word, plus the number of bytes to send and to receive. It takes back the received bytes one per cycle. If the device stays busy for too many polls, or the shifter reports an error, the scan stops for good and raises an error flag.

Once the scan is complete, other logic can ask whether a given block is bad, and can declare a block bad at run time. Declaring a block that is already bad leaves the map and the count unchanged. Both kinds of request are ignored until the scan has finished.

Top module: `nand_bbscan`

## Requirements
- R1: Leaving reset, the engine scans block 0 to block NUM_BLOCKS-1 in ascending order. For block j it first issues a 4-byte frame 0x13, 0x00, row[15:8], row[7:0] with no receive bytes, where row = j*64. Frame byte 0 is carried in lnk_tx[31:24], byte 1 in [23:16], and so on. lnk_req stays high until lnk_done.
- R2: After each page load the engine issues status polls, each a 2-byte frame 0x0F, 0xC0 that receives 1 byte. Bit 0 of the received byte set means busy, and the engine polls again. Bit 0 clear lets the engine move on, whatever the other bits hold.
- R3: If POLL_LIMIT (default 100) polls in a row for one block all report busy, the engine stops. scan_err goes high, scan_done stays low, and no further frames are issued.
- R4: If lnk_err is high together with lnk_done on any frame, the engine stops in the same way as in R3.
- R5: After a ready status the engine issues the 4-byte frame 0x03, 0x08, 0x00, 0x00 and receives 16 bytes. The first received byte is spare byte 0. If spare byte 0 is not 0xFF, the block is bad.
- R6: If spare byte 0 is 0xFF, the block is bad exactly when spare bytes 8, 9, 10 and 11 are 0xDE, 0xAD, 0xBE and 0xEF. Any other value in any of those four bytes leaves the block good.
- R7: When scan_done is high, bad_count equals the number of blocks found bad. It is CNT_W bits wide (11 bits for 1024 blocks).
- R8: After reset, scan_done, scan_err, qry_vld and bad_count are all 0. scan_done goes high once the last block is recorded and stays high.
- R9: A query (qry_req with qry_blk) while scan_done is high gives qry_vld = 1 two cycles later, with qry_bad = 1 when the block is bad. A query before scan_done gives no qry_vld.
- R10: A mark request (mark_req with mark_blk) while scan_done is high sets the block's bit. If the bit was clear, bad_count rises by 1 two cycles later. A mark of a block that is already bad changes nothing. A mark before scan_done is ignored.
- R11: Requests in neighbouring cycles see each other. A query sees any mark requested in an earlier cycle. A second mark of the same block in the next cycle does not count twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the scan restarts when it is released |
| lnk_req | output | 1 | Frame request to the serial shifter, held until lnk_done |
| lnk_tx | output | 32 | Command bytes, first byte in bits 31:24 |
| lnk_tx_len | output | 3 | Number of command bytes to send |
| lnk_rx_len | output | RXL_W (5) | Number of bytes to receive after the command |
| lnk_rx_vld | input | 1 | A received byte is present |
| lnk_rx_byte | input | 8 | Received byte |
| lnk_done | input | 1 | Frame finished (after its last received byte) |
| lnk_err | input | 1 | Frame failed; sampled with lnk_done |
| qry_req | input | 1 | Query strobe |
| qry_blk | input | BLK_W (10) | Block number to query |
| qry_vld | output | 1 | Query answer valid |
| qry_bad | output | 1 | Queried block is bad |
| mark_req | input | 1 | Mark-bad strobe |
| mark_blk | input | BLK_W (10) | Block number to mark bad |
| scan_done | output | 1 | Scan finished without error |
| scan_err | output | 1 | Scan aborted |
| bad_count | output | CNT_W (11) | Number of bad blocks |

## Verification
The bench's shifter model fills the spare area of each block with one of several patterns: clean, factory-marked with a random non-0xFF first byte, carrying the signature, carrying the signature with one byte off by one bit, and carrying both markings. These patterns separate the factory test, the signature test and the rule that both markings together still count once. Each block reports busy for a random number of polls, with random upper status bits. This tells whether only status bit 0 controls the poll loop. A block that never becomes ready, and a shifter error at one block, show the abort path. Marks and queries placed in the same, neighbouring and later cycles show the map's hazard handling and that a repeated mark is not counted again.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_POLL,
    ST_SPARE,
    ST_FIN,
    ST_DONE,
    ST_FAIL
  } scan_st_t;

  localparam logic [7:0] OP_PAGE_LOAD  = 8'h13;
  localparam logic [7:0] OP_GET_REG    = 8'h0F;
  localparam logic [7:0] REG_STATUS    = 8'hC0;
  localparam logic [7:0] OP_READ_CACHE = 8'h03;
  localparam logic [7:0] SPARE_COL_HI  = 8'h08;

  localparam logic [2:0] LEN_PAGE_LOAD = 3'd4;
  localparam logic [2:0] LEN_GET_REG   = 3'd2;
  localparam logic [2:0] LEN_READ      = 3'd4;

endpackage

// File: rtl/nbs_spare_chk.sv
module nbs_spare_chk #(
  parameter int SPARE_BYTES = 16,
  parameter int SIG_OFS     = 8,
  parameter logic [31:0] SIG = 32'hDEADBEEF,
  localparam int IDX_W      = $clog2(SPARE_BYTES + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       rx_vld,
  input  logic [7:0] rx_byte,
  output logic       bad
);

  logic [IDX_W-1:0] idx;
  logic             fac_bad;
  logic             sig_ok;
  logic [3:0]       sig_miss;

  // one comparator per signature byte, first received byte is the MSB of SIG
  for (genvar k = 0; k < 4; k++) begin : g_sig
    assign sig_miss[k] = (idx == IDX_W'(SIG_OFS + k)) &&
                         (rx_byte != SIG[31-8*k -: 8]);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx     <= '0;
      fac_bad <= 1'b0;
      sig_ok  <= 1'b1;
    end else if (rx_vld && (idx < IDX_W'(SPARE_BYTES))) begin
      idx <= idx + 1'b1;
      if ((idx == '0) && (rx_byte != 8'hFF)) fac_bad <= 1'b1;
      if (|sig_miss) sig_ok <= 1'b0;
    end
  end

  // factory mark wins; signature only counts once all four bytes arrived
  assign bad = fac_bad || (sig_ok && (idx >= IDX_W'(SIG_OFS + 4)));

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    idx <= IDX_W'(SPARE_BYTES)); // R5

endmodule

// File: rtl/nbs_seq.sv
module nbs_seq
  import nbs_pkg::*;
#(
  parameter int NUM_BLOCKS  = 1024,
  parameter int PG_SHIFT    = 6,
  parameter int POLL_LIMIT  = 100,
  parameter int SPARE_BYTES = 16,
  localparam int BLK_W      = $clog2(NUM_BLOCKS),
  localparam int PL_W       = $clog2(POLL_LIMIT + 1),
  localparam int RXL_W      = $clog2(SPARE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             lnk_req,
  output logic [31:0]      lnk_tx,
  output logic [2:0]       lnk_tx_len,
  output logic [RXL_W-1:0] lnk_rx_len,
  input  logic             lnk_rx_vld,
  input  logic [7:0]       lnk_rx_byte,
  input  logic             lnk_done,
  input  logic             lnk_err,
  input  logic             spare_bad,
  output logic             chk_clr,
  output logic             scan_wr,
  output logic [BLK_W-1:0] scan_blk,
  output logic             scan_bad,
  output logic             scan_done,
  output logic             scan_err
);

  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  scan_st_t         st;
  logic [BLK_W-1:0] blk;
  logic [PL_W-1:0]  polls;
  logic             busy_q;
  logic [15:0]      row;

  assign row = 16'(blk) << PG_SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_LOAD;
      blk        <= '0;
      polls      <= '0;
      busy_q     <= 1'b0;
      lnk_req    <= 1'b0;
      lnk_tx     <= '0;
      lnk_tx_len <= '0;
      lnk_rx_len <= '0;
      chk_clr    <= 1'b0;
      scan_wr    <= 1'b0;
      scan_blk   <= '0;
      scan_bad   <= 1'b0;
      scan_done  <= 1'b0;
      scan_err   <= 1'b0;
    end else begin
      scan_wr <= 1'b0;
      chk_clr <= 1'b0;
      if (lnk_rx_vld && (st == ST_POLL)) busy_q <= lnk_rx_byte[0];

      case (st)
        ST_LOAD: begin
          if (!lnk_req) begin
            lnk_req    <= 1'b1;
            lnk_tx     <= {OP_PAGE_LOAD, 8'h00, row};
            lnk_tx_len <= LEN_PAGE_LOAD;
            lnk_rx_len <= '0;
          end else if (lnk_done) begin
            lnk_req <= 1'b0;
            polls   <= '0;
            if (lnk_err) begin
              st       <= ST_FAIL;
              scan_err <= 1'b1;
            end else begin
              st <= ST_POLL;
            end
          end
        end

        ST_POLL: begin
          if (!lnk_req) begin
            lnk_req    <= 1'b1;
            lnk_tx     <= {OP_GET_REG, REG_STATUS, 16'h0000};
            lnk_tx_len <= LEN_GET_REG;
            lnk_rx_len <= RXL_W'(1);
          end else if (lnk_done) begin
            lnk_req <= 1'b0;
            if (lnk_err) begin
              st       <= ST_FAIL;
              scan_err <= 1'b1;
            end else if (busy_q) begin
              if (polls == PL_W'(POLL_LIMIT - 1)) begin
                st       <= ST_FAIL;
                scan_err <= 1'b1;
              end else begin
                polls <= polls + 1'b1;
              end
            end else begin
              st <= ST_SPARE;
            end
          end
        end

        ST_SPARE: begin
          if (!lnk_req) begin
            lnk_req    <= 1'b1;
            lnk_tx     <= {OP_READ_CACHE, SPARE_COL_HI, 16'h0000};
            lnk_tx_len <= LEN_READ;
            lnk_rx_len <= RXL_W'(SPARE_BYTES);
            chk_clr    <= 1'b1;
          end else if (lnk_done) begin
            lnk_req <= 1'b0;
            if (lnk_err) begin
              st       <= ST_FAIL;
              scan_err <= 1'b1;
            end else begin
              scan_wr  <= 1'b1;
              scan_blk <= blk;
              scan_bad <= spare_bad;
              if (blk == LAST_BLK) begin
                st <= ST_FIN;
              end else begin
                blk <= blk + 1'b1;
                st  <= ST_LOAD;
              end
            end
          end
        end

        ST_FIN: begin
          scan_done <= 1'b1;
          st        <= ST_DONE;
        end

        ST_DONE: st <= ST_DONE;
        ST_FAIL: st <= ST_FAIL;
        default: begin
          st       <= ST_FAIL;
          scan_err <= 1'b1;
        end
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (lnk_req && !lnk_done) |=> lnk_req); // R1

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
    polls < PL_W'(POLL_LIMIT)); // R3

  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (rst)
    scan_err |=> (scan_err && !lnk_req && !scan_done)); // R4

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> scan_done); // R8

endmodule

// File: rtl/nbs_bitmap.sv
module nbs_bitmap #(
  parameter int NUM_BLOCKS = 1024,
  localparam int BLK_W     = $clog2(NUM_BLOCKS),
  localparam int CNT_W     = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_done,
  input  logic             scan_wr,
  input  logic [BLK_W-1:0] scan_blk,
  input  logic             scan_bad,
  input  logic             qry_req,
  input  logic [BLK_W-1:0] qry_blk,
  input  logic             mark_req,
  input  logic [BLK_W-1:0] mark_blk,
  output logic             qry_vld,
  output logic             qry_bad,
  output logic [CNT_W-1:0] bad_count
);

  localparam logic [BLK_W:0] NB_L = (BLK_W+1)'(NUM_BLOCKS);

  logic             mem [NUM_BLOCKS];
  logic             q_rd, m_rd;
  logic             q_s1, m_s1;
  logic [BLK_W-1:0] q_blk1, m_blk1;
  logic             lw_vld, lw_val;
  logic [BLK_W-1:0] lw_blk;
  logic             q_ok, m_ok, q_bit, m_bit, m_set;
  logic             wr_en, wr_val;
  logic [BLK_W-1:0] wr_blk;

  assign q_ok = qry_req  && scan_done && ({1'b0, qry_blk}  < NB_L);
  assign m_ok = mark_req && scan_done && ({1'b0, mark_blk} < NB_L);

  // memory: one write port, two synchronous read ports, no reset
  always_ff @(posedge clk) begin
    q_rd <= mem[qry_blk];
    m_rd <= mem[mark_blk];
    if (wr_en) mem[wr_blk] <= wr_val;
  end

  // forward the write of the previous edge, which the read ports missed
  assign q_bit = (lw_vld && (lw_blk == q_blk1)) ? lw_val : q_rd;
  assign m_bit = (lw_vld && (lw_blk == m_blk1)) ? lw_val : m_rd;
  assign m_set = m_s1 && !m_bit;

  assign wr_en  = scan_wr || m_set;
  assign wr_blk = scan_wr ? scan_blk : m_blk1;
  assign wr_val = scan_wr ? scan_bad : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_s1      <= 1'b0;
      m_s1      <= 1'b0;
      q_blk1    <= '0;
      m_blk1    <= '0;
      lw_vld    <= 1'b0;
      lw_val    <= 1'b0;
      lw_blk    <= '0;
      qry_vld   <= 1'b0;
      qry_bad   <= 1'b0;
      bad_count <= '0;
    end else begin
      q_s1    <= q_ok;
      m_s1    <= m_ok;
      q_blk1  <= qry_blk;
      m_blk1  <= mark_blk;
      lw_vld  <= wr_en;
      lw_val  <= wr_val;
      lw_blk  <= wr_blk;
      qry_vld <= q_s1;
      qry_bad <= q_s1 && q_bit;
      if ((scan_wr && scan_bad) || m_set) bad_count <= bad_count + 1'b1;
    end
  end

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    bad_count <= CNT_W'(NUM_BLOCKS)); // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (bad_count == $past(bad_count)) || (bad_count == $past(bad_count) + 1'b1)); // R10

  AST_MARK_NOOP: assert property (@(posedge clk) disable iff (rst)
    (m_s1 && m_bit && !scan_wr) |=> (bad_count == $past(bad_count))); // R10

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(scan_wr && m_s1)); // R10

  AST_QRY_GATED: assert property (@(posedge clk) disable iff (rst)
    qry_vld |-> scan_done); // R9

endmodule

// File: rtl/nand_bbscan.sv
module nand_bbscan #(
  parameter int NUM_BLOCKS  = 1024,
  parameter int PG_SHIFT    = 6,
  parameter int POLL_LIMIT  = 100,
  parameter int SPARE_BYTES = 16,
  parameter int SIG_OFS     = 8,
  parameter logic [31:0] SIG = 32'hDEADBEEF,
  localparam int BLK_W      = $clog2(NUM_BLOCKS),
  localparam int CNT_W      = $clog2(NUM_BLOCKS + 1),
  localparam int RXL_W      = $clog2(SPARE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             lnk_req,
  output logic [31:0]      lnk_tx,
  output logic [2:0]       lnk_tx_len,
  output logic [RXL_W-1:0] lnk_rx_len,
  input  logic             lnk_rx_vld,
  input  logic [7:0]       lnk_rx_byte,
  input  logic             lnk_done,
  input  logic             lnk_err,
  input  logic             qry_req,
  input  logic [BLK_W-1:0] qry_blk,
  output logic             qry_vld,
  output logic             qry_bad,
  input  logic             mark_req,
  input  logic [BLK_W-1:0] mark_blk,
  output logic             scan_done,
  output logic             scan_err,
  output logic [CNT_W-1:0] bad_count
);

  logic             spare_bad, chk_clr;
  logic             scan_wr, scan_bad;
  logic [BLK_W-1:0] scan_blk;

  nbs_spare_chk #(
    .SPARE_BYTES(SPARE_BYTES),
    .SIG_OFS    (SIG_OFS),
    .SIG        (SIG)
  ) i_chk (
    .clk    (clk),
    .rst    (rst),
    .clr    (chk_clr),
    .rx_vld (lnk_rx_vld),
    .rx_byte(lnk_rx_byte),
    .bad    (spare_bad)
  );

  nbs_seq #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .PG_SHIFT   (PG_SHIFT),
    .POLL_LIMIT (POLL_LIMIT),
    .SPARE_BYTES(SPARE_BYTES)
  ) i_seq (
    .clk        (clk),
    .rst        (rst),
    .lnk_req    (lnk_req),
    .lnk_tx     (lnk_tx),
    .lnk_tx_len (lnk_tx_len),
    .lnk_rx_len (lnk_rx_len),
    .lnk_rx_vld (lnk_rx_vld),
    .lnk_rx_byte(lnk_rx_byte),
    .lnk_done   (lnk_done),
    .lnk_err    (lnk_err),
    .spare_bad  (spare_bad),
    .chk_clr    (chk_clr),
    .scan_wr    (scan_wr),
    .scan_blk   (scan_blk),
    .scan_bad   (scan_bad),
    .scan_done  (scan_done),
    .scan_err   (scan_err)
  );

  nbs_bitmap #(
    .NUM_BLOCKS(NUM_BLOCKS)
  ) i_map (
    .clk      (clk),
    .rst      (rst),
    .scan_done(scan_done),
    .scan_wr  (scan_wr),
    .scan_blk (scan_blk),
    .scan_bad (scan_bad),
    .qry_req  (qry_req),
    .qry_blk  (qry_blk),
    .mark_req (mark_req),
    .mark_blk (mark_blk),
    .qry_vld  (qry_vld),
    .qry_bad  (qry_bad),
    .bad_count(bad_count)
  );

endmodule

// File: tb/test_nand_bbscan.sv
`timescale 1ns/100ps
module test_nand_bbscan;
  localparam int NB = 1024;
  localparam int PLIM = 100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lnk_req;
  logic [31:0] lnk_tx;
  logic [2:0]  lnk_tx_len;
  logic [4:0]  lnk_rx_len;
  logic        lnk_rx_vld = 1'b0;
  logic [7:0]  lnk_rx_byte = 8'h00;
  logic        lnk_done = 1'b0;
  logic        lnk_err = 1'b0;
  logic        qry_req = 1'b0;
  logic [9:0]  qry_blk = '0;
  logic        qry_vld, qry_bad;
  logic        mark_req = 1'b0;
  logic [9:0]  mark_blk = '0;
  logic        scan_done, scan_err;
  logic [10:0] bad_count;

  always #2.5 clk = ~clk;

  nand_bbscan i_nand_bbscan (.*);

  int errors = 0, checks = 0;
  int kind [NB];
  logic [7:0] b0 [NB];
  int busy_n [NB];
  logic exp_tab [NB];
  int stuck_blk = -1, err_blk = -1;
  int exp_blk = 0, cur_blk = 0, polls_this = 0, txn_cnt = 0, poll_total = 0;
  int bad_r1 = 0, bad_r2 = 0, bad_r5 = 0;
  logic [7:0] resp [16];
  int mn;
  logic inj;

  // kinds: 0-3 clean, 4 factory, 5 signature, 6 signature off by one bit, 7 both
  function automatic logic [7:0] spare_at(int j, int i);
    logic [31:0] sig = 32'hDEADBEEF;
    logic [7:0] v;
    if (i == 0) v = (kind[j] == 4 || kind[j] == 7) ? b0[j] : 8'hFF;
    else if (i >= 8 && i <= 11) begin
      if (kind[j] >= 5) begin
        v = sig[31-8*(i-8) -: 8];
        if (kind[j] == 6 && (i - 8) == (j % 4)) v = v ^ 8'h01;
      end else v = 8'h10 + 8'(i);
    end else v = 8'hA5 ^ 8'(i);
    return v;
  endfunction

  function automatic logic is_bad(int k);
    return (k >= 4) && (k != 6);
  endfunction

  task automatic chk(input logic ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // shifter model
  initial begin : model
    forever begin
      @(negedge clk);
      if (!rst && lnk_req) begin
        txn_cnt++;
        mn = int'(lnk_rx_len);
        inj = 1'b0;
        case (lnk_tx[31:24])
          8'h13: begin
            if (lnk_tx[15:0] != 16'(exp_blk << 6) || lnk_tx_len != 3'd4 ||
                lnk_tx[23:16] != 8'h00 || lnk_rx_len != 5'd0) bad_r1++;
            cur_blk = int'(lnk_tx[15:6]);
            polls_this = 0;
            if (cur_blk == err_blk) inj = 1'b1;
          end
          8'h0F: begin
            if (lnk_tx[23:16] != 8'hC0 || lnk_tx_len != 3'd2 || lnk_rx_len != 5'd1) bad_r2++;
            if (cur_blk == stuck_blk || polls_this < busy_n[cur_blk])
              resp[0] = 8'($urandom) | 8'h01;
            else
              resp[0] = 8'($urandom) & 8'hFE;
            polls_this++;
            poll_total++;
          end
          8'h03: begin
            if (lnk_tx[23:0] != 24'h080000 || lnk_tx_len != 3'd4 || lnk_rx_len != 5'd16) bad_r5++;
            for (int i = 0; i < 16; i++) resp[i] = spare_at(cur_blk, i);
            exp_blk++;
          end
          default: bad_r1++;
        endcase
        repeat (2) @(negedge clk);
        for (int i = 0; i < mn; i++) begin
          lnk_rx_vld = 1'b1;
          lnk_rx_byte = resp[i];
          @(negedge clk);
        end
        lnk_rx_vld = 1'b0;
        lnk_done = 1'b1;
        lnk_err = inj;
        @(negedge clk);
        lnk_done = 1'b0;
        lnk_err = 1'b0;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    exp_blk = 0;
    polls_this = 0;
    poll_total = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_end();
    while (!(scan_done || scan_err)) @(negedge clk);
  endtask

  task automatic query(input int b, output logic v, output logic bd);
    @(negedge clk);
    qry_req = 1'b1;
    qry_blk = 10'(b);
    @(negedge clk);
    qry_req = 1'b0;
    @(negedge clk);
    v = qry_vld;
    bd = qry_bad;
  endtask

  task automatic mark(input int b);
    @(negedge clk);
    mark_req = 1'b1;
    mark_blk = 10'(b);
    @(negedge clk);
    mark_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (R8 completion) actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin : main
    int cnt_exp, t0, g, g2, g3;
    logic v, bd, seen;
    void'($urandom(32'd5150));
    for (int j = 0; j < NB; j++) begin
      kind[j] = int'($urandom % 8);
      b0[j] = 8'($urandom % 255);
      busy_n[j] = int'($urandom % 4);
    end
    kind[0] = 0; kind[1] = 4; b0[1] = 8'hFE; kind[2] = 6; kind[3] = 5;
    kind[4] = 0; kind[5] = 4; b0[5] = 8'h00; kind[6] = 1; kind[7] = 2;
    kind[NB-2] = 7; kind[NB-1] = 5;
    cnt_exp = 0;
    for (int j = 0; j < NB; j++) begin
      exp_tab[j] = is_bad(kind[j]);
      if (exp_tab[j]) cnt_exp++;
    end

    // reset state
    repeat (3) @(negedge clk);
    chk(scan_done == 1'b0 && scan_err == 1'b0, "R8 reset flags", {scan_done, scan_err}, 0);
    chk(bad_count == 11'd0, "R8 reset count", bad_count, 0);
    chk(qry_vld == 1'b0, "R8 reset qry_vld", qry_vld, 0);

    // stuck busy at block 5
    stuck_blk = 5;
    do_reset();
    wait_end();
    chk(scan_err == 1'b1 && scan_done == 1'b0, "R3 abort flags", {scan_done, scan_err}, 1);
    chk(polls_this == PLIM, "R3 poll count", polls_this, PLIM);
    t0 = txn_cnt;
    repeat (60) @(negedge clk);
    chk(txn_cnt == t0, "R3 quiet after abort", txn_cnt, t0);
    chk(cur_blk == 5, "R3 stopping block", cur_blk, 5);

    // shifter error at page load of block 3
    stuck_blk = -1;
    err_blk = 3;
    do_reset();
    wait_end();
    chk(scan_err == 1'b1 && scan_done == 1'b0, "R4 abort flags", {scan_done, scan_err}, 1);
    t0 = txn_cnt;
    repeat (60) @(negedge clk);
    chk(txn_cnt == t0, "R4 quiet after abort", txn_cnt, t0);
    chk(exp_blk == 3, "R4 blocks finished before error", exp_blk, 3);

    // full scan
    err_blk = -1;
    bad_r1 = 0; bad_r2 = 0; bad_r5 = 0;
    do_reset();
    while (exp_blk < 3) @(negedge clk);
    @(negedge clk);
    qry_req = 1'b1; qry_blk = 10'd0;
    mark_req = 1'b1; mark_blk = 10'd0;
    @(negedge clk);
    qry_req = 1'b0; mark_req = 1'b0;
    seen = 1'b0;
    repeat (5) begin
      @(negedge clk);
      if (qry_vld) seen = 1'b1;
    end
    chk(!seen, "R9 query before done ignored", seen, 0);
    wait_end();
    chk(scan_done == 1'b1 && scan_err == 1'b0, "R8 scan completes", {scan_done, scan_err}, 2);
    chk(bad_r1 == 0 && exp_blk == NB, "R1 page load frames and order", bad_r1, 0);
    chk(bad_r2 == 0, "R2 poll frames", bad_r2, 0);
    begin
      int pe = 0;
      for (int j = 0; j < NB; j++) pe += busy_n[j] + 1;
      chk(poll_total == pe, "R2 polls until bit0 clear", poll_total, pe);
    end
    chk(bad_r5 == 0, "R5 spare read frames", bad_r5, 0);
    chk(bad_count == 11'(cnt_exp), "R7 bad count", bad_count, cnt_exp);
    for (int j = 0; j < NB; j++) begin
      query(j, v, bd);
      if (kind[j] >= 5)
        chk(v && bd == exp_tab[j], $sformatf("R6 block %0d kind %0d", j, kind[j]), {v, bd}, {1'b1, exp_tab[j]});
      else
        chk(v && bd == exp_tab[j], $sformatf("R5 block %0d kind %0d", j, kind[j]), {v, bd}, {1'b1, exp_tab[j]});
    end
    query(0, v, bd);
    chk(v && !bd, "R10 mark before done ignored", bd, 0);
    chk(bad_count == 11'(cnt_exp), "R10 count after early mark", bad_count, cnt_exp);
    chk(scan_done == 1'b1, "R8 done sticky", scan_done, 1);

    // marks
    g = 4; g2 = 6; g3 = 7;
    mark(g);
    cnt_exp++; exp_tab[g] = 1'b1;
    chk(bad_count == 11'(cnt_exp), "R10 mark good block count", bad_count, cnt_exp);
    query(g, v, bd);
    chk(v && bd, "R10 marked block reads bad", bd, 1);
    mark(g);
    chk(bad_count == 11'(cnt_exp), "R10 repeat mark no count", bad_count, cnt_exp);
    mark(1);
    chk(bad_count == 11'(cnt_exp), "R10 mark factory bad no count", bad_count, cnt_exp);

    @(negedge clk);
    mark_req = 1'b1; mark_blk = 10'(g2);
    @(negedge clk);
    @(negedge clk);
    mark_req = 1'b0;
    repeat (2) @(negedge clk);
    cnt_exp++; exp_tab[g2] = 1'b1;
    chk(bad_count == 11'(cnt_exp), "R11 back-to-back marks count once", bad_count, cnt_exp);

    @(negedge clk);
    mark_req = 1'b1; mark_blk = 10'(g3);
    @(negedge clk);
    mark_req = 1'b0;
    qry_req = 1'b1; qry_blk = 10'(g3);
    @(negedge clk);
    qry_req = 1'b0;
    @(negedge clk);
    cnt_exp++; exp_tab[g3] = 1'b1;
    chk(qry_vld && qry_bad, "R11 query after mark sees it", {qry_vld, qry_bad}, 3);
    chk(bad_count == 11'(cnt_exp), "R11 count after mark", bad_count, cnt_exp);

    // random marks and queries
    for (int n = 0; n < 200; n++) begin
      int b = int'($urandom % NB);
      if ($urandom % 4 == 0) begin
        mark(b);
        if (!exp_tab[b]) begin
          exp_tab[b] = 1'b1;
          cnt_exp++;
        end
        chk(bad_count == 11'(cnt_exp), $sformatf("R10 random mark %0d", b), bad_count, cnt_exp);
      end else begin
        query(b, v, bd);
        chk(v && bd == exp_tab[b], $sformatf("R9 random query %0d", b), {v, bd}, {1'b1, exp_tab[b]});
      end
    end

    summary();
    $finish;
  end

endmodule